// File: doc/BRIEF.md
# Burst DRAM Read Responder

This block stands in for the memory side of a cache line fill. A requester presents a start word address and a beat count on a valid/ready handshake. After acceptance the block holds off for a CAS-style access latency, then streams one 64-bit word per cycle at consecutive word addresses and flags the final word. When a request starts exactly where the previous burst stopped, the open access is reused and the first word arrives one cycle after acceptance instead of after the full latency.

A free-running refresh timer falls due at a fixed interval. While a refresh runs, no new access may begin and the request port is held off. A refresh that falls due during a burst is postponed until that burst's last word has been delivered. Read data is a fixed, computable function of the word address, so every word can be predicted by whoever checks it.

Top module: `burst_read_responder`

## Requirements
- R1: While reset is asserted and in the first cycle after release, rsp_valid is low and req_ready is high.
- R2: A request is accepted in a cycle where req_valid and req_ready are both high. Unless R5 applies, the first word is valid exactly CAS_LAT cycles after the accept cycle, and rsp_valid stays low in between.
- R3: A burst carries req_len+1 words (req_len is the beat count minus one) on consecutive cycles at consecutive word addresses starting at req_addr. rsp_last is high on the final word only, and rsp_valid is low in the cycle after it.
- R4: Each word equals, bit by bit, rsp_data[i] = addr[i mod ADDR_W] XOR DATA_SEED[i], where addr is that word's address and DATA_SEED defaults to 64'h3C5A_96F0_A50F_C369.
- R5: If the previous burst ended at word address E, the new request's address equals E+1, and no refresh ran since that burst, the first word is valid in the cycle after the accept cycle.
- R6: req_ready is low from the cycle after acceptance through the final word, and, when no refresh is due, high again in the cycle after the final word.
- R7: Counting the cycle of reset release as cycle 0, a refresh falls due in every cycle c with c mod RFSH_INTERVAL = RFSH_INTERVAL-1. With no burst in progress, req_ready is low in that cycle and in the RFSH_LEN cycles that follow.
- R8: A refresh falling due between the cycle after acceptance and the final word leaves the burst's words untouched and holds req_ready low for exactly RFSH_LEN cycles starting in the cycle after the final word.
- R9: After any refresh, a request at the continuation address of the previous burst pays the full CAS_LAT latency.
- R10: Word addresses wrap modulo 2^ADDR_W within a burst, and data for wrapped words follows R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W (16) | Start word address |
| req_len | input | LEN_W (4) | Number of words minus one |
| rsp_valid | output | 1 | Data word valid |
| rsp_last | output | 1 | Final word of the burst |
| rsp_data | output | DATA_W (64) | Data word |

## Verification
The hardest situation to reach is a refresh falling due while a burst is in flight, together with its interaction with the continuation shortcut, because the requester has no view of the refresh timer. The stimulus runs bursts of every length back to back, alternating fresh addresses, continuation addresses and addresses near the top of the space, so the refresh due point lands in the wait phase, the data phase and the idle gap over the run. The expected due cycles are derived arithmetically from the reset release, which lets each post-burst hold-off length and each first-word latency be predicted exactly.

// File: rtl/brr_pkg.sv
package brr_pkg;
  typedef enum logic [1:0] {
    BRR_IDLE = 2'd0,
    BRR_WAIT = 2'd1,
    BRR_BEAT = 2'd2,
    BRR_RFSH = 2'd3
  } brr_state_e;
endpackage

// File: rtl/brr_refresh_tick.sv
module brr_refresh_tick #(
  parameter int INTERVAL = 256
) (
  input  logic clk,
  input  logic rst_n,
  output logic due
);
  localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] TOP = TW'(INTERVAL - 1);

  logic [TW-1:0] tmr_q, tmr_n;

  always_comb begin
    tmr_n = (tmr_q == TOP) ? '0 : tmr_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_n;
  end

  assign due = (tmr_q == TOP);

  // R7: a due cycle is a single-cycle event
  a_r7_single_due: assert property (@(posedge clk) disable iff (!rst_n)
    due |=> !due);
endmodule

// File: rtl/brr_pattern.sv
module brr_pattern #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter logic [DATA_W-1:0] SEED = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign data[i] = addr[i % ADDR_W] ^ SEED[i];
  end
endmodule

// File: rtl/brr_sequencer.sv
module brr_sequencer
  import brr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LEN_W    = 4,
  parameter int CAS_LAT  = 5,
  parameter int RFSH_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              due,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  output logic              beat_valid,
  output logic              beat_last,
  output logic [ADDR_W-1:0] beat_addr
);
  localparam int CMAX = (CAS_LAT > RFSH_LEN) ? CAS_LAT : RFSH_LEN;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] WAIT_LOAD = CW'(CAS_LAT - 2);
  localparam logic [CW-1:0] RFSH_LOAD = CW'(RFSH_LEN - 1);

  brr_state_e        state_q, state_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [LEN_W-1:0]  left_q, left_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              pend_q, pend_n;
  logic              cont_q, cont_n;
  logic              accept, go_rfsh, hit;

  assign req_ready = (state_q == BRR_IDLE) && !pend_q && !due;
  assign accept    = req_valid && req_ready;
  assign go_rfsh   = pend_q || due;
  assign hit       = cont_q && (req_addr == addr_q);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    left_n  = left_q;
    addr_n  = addr_q;
    pend_n  = pend_q | due;
    cont_n  = cont_q;
    case (state_q)
      BRR_IDLE: begin
        if (accept) begin
          addr_n = req_addr;
          left_n = req_len;
          if (hit) begin
            state_n = BRR_BEAT;
          end else begin
            state_n = BRR_WAIT;
            cnt_n   = WAIT_LOAD;
          end
        end else if (go_rfsh) begin
          state_n = BRR_RFSH;
          cnt_n   = RFSH_LOAD;
          pend_n  = 1'b0;
          cont_n  = 1'b0;
        end
      end
      BRR_WAIT: begin
        if (cnt_q == '0) state_n = BRR_BEAT;
        else             cnt_n   = cnt_q - CW'(1);
      end
      BRR_BEAT: begin
        addr_n = addr_q + ADDR_W'(1);
        if (left_q == '0) begin
          cont_n = 1'b1;
          if (go_rfsh) begin
            state_n = BRR_RFSH;
            cnt_n   = RFSH_LOAD;
            pend_n  = 1'b0;
            cont_n  = 1'b0;
          end else begin
            state_n = BRR_IDLE;
          end
        end else begin
          left_n = left_q - LEN_W'(1);
        end
      end
      default: begin
        if (cnt_q == '0) state_n = BRR_IDLE;
        else             cnt_n   = cnt_q - CW'(1);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BRR_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
      addr_q  <= '0;
      pend_q  <= 1'b0;
      cont_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      pend_q  <= pend_n;
      cont_q  <= cont_n;
      if (accept || state_q == BRR_BEAT) begin
        left_q <= left_n;
        addr_q <= addr_n;
      end
    end
  end

  assign beat_valid = (state_q == BRR_BEAT);
  assign beat_last  = beat_valid && (left_q == '0);
  assign beat_addr  = addr_q;

  // R2: a fresh access shows no word in the cycle after acceptance
  a_r2_no_early_word: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> !beat_valid);
  // R3: words of one burst walk through consecutive addresses
  a_r3_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid)) |-> (beat_addr == $past(beat_addr) + ADDR_W'(1)));
  // R3: the final word closes the burst
  a_r3_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> !beat_valid);
  // R8: nothing interrupts a burst before its final word
  a_r8_no_break: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=> beat_valid);
  // R6: the port closes once a request is taken
  a_r6_closed_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R7: refresh only starts when one is owed
  a_r7_refresh_owed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == BRR_RFSH) |-> $past(go_rfsh));
endmodule

// File: rtl/burst_read_responder.sv
module burst_read_responder #(
  parameter int ADDR_W        = 16,
  parameter int LEN_W         = 4,
  parameter int DATA_W        = 64,
  parameter int CAS_LAT       = 5,
  parameter int RFSH_INTERVAL = 256,
  parameter int RFSH_LEN      = 8,
  parameter logic [DATA_W-1:0] DATA_SEED = DATA_W'(64'h3C5A_96F0_A50F_C369)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              rsp_valid,
  output logic              rsp_last,
  output logic [DATA_W-1:0] rsp_data
);
  logic              due;
  logic [ADDR_W-1:0] beat_addr;

  brr_refresh_tick #(
    .INTERVAL (RFSH_INTERVAL)
  ) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .due   (due)
  );

  brr_sequencer #(
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .CAS_LAT  (CAS_LAT),
    .RFSH_LEN (RFSH_LEN)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .due        (due),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .req_ready  (req_ready),
    .beat_valid (rsp_valid),
    .beat_last  (rsp_last),
    .beat_addr  (beat_addr)
  );

  brr_pattern #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEED   (DATA_SEED)
  ) u_pat (
    .addr (beat_addr),
    .data (rsp_data)
  );

  // R3: last flag only accompanies a valid word
  a_r3_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid);
endmodule

// File: tb/burst_read_responder_tb_top.sv
`timescale 1ns/1ps
module burst_read_responder_tb_top;
  localparam int AW = 16;
  localparam int LW = 4;
  localparam int CL = 5;
  localparam int RI = 256;
  localparam int RL = 8;
  localparam logic [63:0] SEED = 64'h3C5A_96F0_A50F_C369;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic          rsp_valid;
  logic          rsp_last;
  logic [63:0]   rsp_data;

  burst_read_responder dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .rsp_valid (rsp_valid),
    .rsp_last  (rsp_last),
    .rsp_data  (rsp_data)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int n_def  = 0;
  int n_seq  = 0;
  bit done   = 1'b0;
  bit prev_ok = 1'b0;
  bit ref_since = 1'b0;
  logic [AW-1:0] prev_next = '0;

  function automatic logic [63:0] exp_data(input logic [AW-1:0] a);
    logic [63:0] d;
    for (int i = 0; i < 64; i++) d[i] = a[i % AW] ^ SEED[i];
    return d;
  endfunction

  function automatic bit is_due(input int c);
    return (c % RI) == RI - 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d act=%h exp=%h", tag, cyc, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      tick();
      if (!req_ready) ref_since = 1'b1;
      chk(rsp_valid == 1'b0, "R3 idle", 64'(rsp_valid), 64'd0);
    end
  endtask

  task automatic run_burst(input logic [AW-1:0] a, input logic [LW-1:0] len);
    bit seq, deferred;
    int lat, run, exp_run;
    string ltag;
    req_addr  = a;
    req_len   = len;
    req_valid = 1'b1;
    while (!req_ready) begin
      ref_since = 1'b1;
      tick();
    end
    seq = prev_ok && !ref_since && (a == prev_next);
    lat = seq ? 1 : CL;
    if (seq) n_seq++;
    ltag = seq ? "R5" : ((prev_ok && a == prev_next) ? "R9" : "R2");
    deferred = 1'b0;
    for (int t = 1; t <= lat + int'(len); t++) begin
      logic [AW-1:0] ba;
      tick();
      if (t == 1) req_valid = 1'b0;
      if (is_due(cyc)) deferred = 1'b1;
      if (t < lat) begin
        chk(rsp_valid == 1'b0, ltag, 64'(rsp_valid), 64'd0);
      end else begin
        ba = a + AW'(t - lat);
        chk(rsp_valid == 1'b1, ltag, 64'(rsp_valid), 64'd1);
        chk(rsp_data == exp_data(ba), (ba < a) ? "R10" : "R4", rsp_data, exp_data(ba));
        chk(rsp_last == (t == lat + int'(len)), "R3", 64'(rsp_last), 64'(t == lat + int'(len)));
      end
      chk(req_ready == 1'b0, "R6", 64'(req_ready), 64'd0);
    end
    tick();
    chk(rsp_valid == 1'b0, "R3 after last", 64'(rsp_valid), 64'd0);
    exp_run = deferred ? RL : (is_due(cyc) ? RL + 1 : 0);
    run = 0;
    while (!req_ready && run <= RL + 2) begin
      run++;
      tick();
    end
    chk(run == exp_run, deferred ? "R8" : "R6", 64'(run), 64'(exp_run));
    if (deferred) n_def++;
    ref_since = (run > 0);
    prev_ok   = 1'b1;
    prev_next = a + AW'(len) + AW'(1);
  endtask

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    req_len   = '0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    cyc   = 0;
    chk(rsp_valid == 1'b0, "R1", 64'(rsp_valid), 64'd0);
    chk(req_ready == 1'b1, "R1", 64'(req_ready), 64'd1);

    // idle refresh schedule
    for (int k = 0; k < 2 * RI + RL + 4; k++) begin
      bit exp_low;
      tick();
      exp_low = (cyc >= RI - 1) && (((cyc + 1) % RI) <= RL);
      chk(req_ready == !exp_low, "R7", 64'(req_ready), 64'(!exp_low));
      chk(rsp_valid == 1'b0, "R7", 64'(rsp_valid), 64'd0);
    end
    ref_since = 1'b1;

    // sweep every length over fresh, continuation and wrapping addresses
    for (int len = 0; len < 16; len++) begin
      run_burst(AW'(16'h0100 + len * 64), LW'(len));
      run_burst(prev_next, LW'(len));
      run_burst(AW'(16'hFFFF - len / 2), LW'(len));
      run_burst(prev_next, LW'(15 - len));
    end

    // continuation after an idle refresh must pay full latency
    run_burst(16'h2000, 4'd3);
    idle(RI + RL + 2);
    run_burst(prev_next, 4'd3);

    chk(n_def > 0, "R8 coverage", 64'(n_def), 64'd1);
    chk(n_seq > 0, "R5 coverage", 64'(n_seq), 64'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2 act=hung exp=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule